// File: doc/BRIEF.md
# Receive Ring Dequeue Controller

This block takes one received frame at a time out of a circular receive buffer held in an external byte-addressable memory. Each frame in the ring starts with a six-byte status header. The header gives the address where the following frame begins and the stored byte count of this frame. When software or a sequencer raises `start`, the block first looks at the pending-frame count. If frames are pending, it walks the stored frame. It captures the next-frame address and the byte count. It skips to the six bytes just before the type/length field and captures them as the sender MAC. It then reads the type/length field itself. If the field carries a length that fits in one byte, up to that many payload bytes go out on a byte stream, limited by a requested maximum and by the frame byte count.

When the frame has been handled, the block gives the space back. It writes a release pointer one below the next-frame address, clamped to the ring end so that the pointer stays inside the ring. In the cycle after that write, it pulses a decrement for the pending-frame counter. The next-frame address stays in a register, so the next dequeue begins exactly where the previous one pointed.

Memory reads use a request channel (`mem_req_valid`/`mem_req_ready`) and a response strobe. Only one read is outstanding at a time, and the address is held while a request waits. The payload leaves on a valid/ready stream. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` do not change. The block never drops a byte, and it never skips one under back-pressure.

Top module: `rdq_dequeue`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `out_valid`, `mem_req_valid`, `rel_we` and `pkt_dec` are 0, and the first dequeue reads its header starting at the ring start address 0.
- R2: A `start` seen while `pkt_count` is 0 raises `done` in the next cycle with `out_len` 0. It issues no memory read, no payload, no release write and no decrement.
- R3: Frame offsets 0 and 1 hold the next-frame address, low byte first. Offsets 2 and 3 hold the frame byte count, low byte first. Offsets 4 and 5 are not used.
- R4: The deliverable length is the smaller of `max_len` and (byte count − 14), and it is 0 when the byte count is 14 or less.
- R5: `src_mac` holds the six bytes at frame offsets 12 to 17. The byte at offset 12 lands in bits 47:40, and later bytes go to lower bit positions in turn.
- R6: The type/length field sits at frame offsets 18 (high) and 19 (low). A non-zero high byte gives `out_len` 0 with no payload beats.
- R7: With a zero high byte, `out_len` is the smaller of the low byte and the R4 limit. That many bytes, taken from offset 20 onward, leave on the stream in address order, and `out_last` marks the final byte.
- R8: Every read address lies in the ring (0 to 0x19FD). An address that would step past 0x19FD continues at 0, for header, MAC, type and payload bytes alike.
- R9: `rel_ptr`, presented with a one-cycle `rel_we`, equals next-frame − 1. When next-frame − 1 would fall below the ring start or above 0x19FD, it equals 0x19FD.
- R10: `pkt_dec` pulses for exactly one cycle, in the cycle right after `rel_we`. `done` rises in that same cycle, and the result is valid there.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged.
- R12: The next-frame address from one dequeue is kept. The next dequeue's first memory read uses that address.
- R13: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` stays high and `mem_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one dequeue; taken while idle |
| pkt_count | input | 8 | Number of frames waiting in the ring |
| max_len | input | 8 | Largest payload the consumer accepts |
| busy | output | 1 | A dequeue is in progress |
| done | output | 1 | One-cycle end-of-dequeue strobe |
| out_len | output | 8 | Number of payload bytes delivered |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 13 | Byte address of the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| out_valid | output | 1 | Payload byte valid |
| out_ready | input | 1 | Consumer accepts the payload byte |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Final payload byte of this frame |
| src_mac | output | 48 | Captured sender MAC |
| rel_we | output | 1 | Release pointer write strobe |
| rel_ptr | output | 13 | Release pointer value |
| pkt_dec | output | 1 | Decrement pulse for the pending count |

## Verification
On every cycle, the assertions check the handshake rules on both channels and that every read address stays inside the ring. They also check that each decrement is a single pulse following a release write, and that a start on an empty count ends at once without a memory read. The values themselves can only be shown by the bench scenarios: header decoding, the two length clamps, the MAC byte order, the wrap of MAC and payload bytes across the ring end, the release-pointer clamp, and the carry-over of the next-frame address between dequeues.

// File: rtl/rdq_pkg.sv
package rdq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EMPTY,
    S_REQ,
    S_WAIT,
    S_CALC,
    S_OUT,
    S_REL,
    S_DEC
  } rdq_state_e;

  // bytes of link header and status not counted as payload
  localparam int FRAME_OVERHEAD = 14;
  // distance from header byte 3 to frame offset 12
  localparam int SKIP_TO_MAC = 9;

  localparam logic [3:0] IDX_TYPE_HI = 4'd10;
  localparam logic [3:0] IDX_TYPE_LO = 4'd11;
  localparam logic [3:0] IDX_PAYLOAD = 4'd12;

endpackage

// File: rtl/rdq_ring_math.sv
module rdq_ring_math #(
  parameter int AW         = 13,
  parameter int RING_START = 0,
  parameter int RING_END   = 13'h19FD,
  parameter int SKIP       = 9
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] nxt_frame,
  output logic [AW-1:0] step_addr,
  output logic [AW-1:0] skip_addr,
  output logic [AW-1:0] rel_addr
);
  localparam logic [AW-1:0] START_A = AW'(RING_START);
  localparam logic [AW-1:0] END_A   = AW'(RING_END);
  localparam logic [AW:0]   END_X   = (AW+1)'(RING_END);
  localparam logic [AW:0]   SIZE_X  = (AW+1)'(RING_END - RING_START + 1);

  logic [AW:0]   skip_sum;
  logic [AW-1:0] rel_dec;

  // single step with wrap at the ring end
  assign step_addr = (cur_addr == END_A) ? START_A : cur_addr + 1'b1;

  // multi-byte jump, folded back by one ring size
  assign skip_sum  = {1'b0, cur_addr} + (AW+1)'(SKIP);
  assign skip_addr = AW'((skip_sum > END_X) ? skip_sum - SIZE_X : skip_sum);

  // release one below next frame, clamped into the ring
  assign rel_dec  = nxt_frame - 1'b1;
  assign rel_addr = ((nxt_frame <= START_A) || (rel_dec > END_A)) ? END_A : rel_dec;

endmodule

// File: rtl/rdq_len_calc.sv
module rdq_len_calc #(
  parameter int LW       = 8,
  parameter int CW       = 16,
  parameter int OVERHEAD = 14
) (
  input  logic [CW-1:0] byte_cnt,
  input  logic [LW-1:0] max_len,
  input  logic          type_hi_zero,
  input  logic [LW-1:0] type_lo,
  output logic [LW-1:0] deliver_len
);
  logic [CW-1:0] room;
  logic [CW-1:0] max_ext;
  logic [LW-1:0] limit;

  assign room    = (byte_cnt > CW'(OVERHEAD)) ? byte_cnt - CW'(OVERHEAD) : '0;
  assign max_ext = {{(CW-LW){1'b0}}, max_len};
  assign limit   = (room < max_ext) ? room[LW-1:0] : max_len;

  assign deliver_len = !type_hi_zero ? '0 :
                       ((type_lo < limit) ? type_lo : limit);

endmodule

// File: rtl/rdq_seq.sv
module rdq_seq
  import rdq_pkg::*;
#(
  parameter int AW         = 13,
  parameter int LW         = 8,
  parameter int CW         = 16,
  parameter int PCW        = 8,
  parameter int RING_START = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [PCW-1:0] pkt_count,
  input  logic [LW-1:0]  max_len,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [AW-1:0]  cur_addr,
  input  logic           mem_rsp_valid,
  input  logic [7:0]     mem_rdata,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [7:0]     out_data,
  output logic           out_last,
  input  logic [AW-1:0]  step_addr,
  input  logic [AW-1:0]  skip_addr,
  input  logic [LW-1:0]  deliver_len,
  output logic [AW-1:0]  nxt_frame,
  output logic [CW-1:0]  byte_cnt,
  output logic           type_hi_zero,
  output logic [LW-1:0]  type_lo,
  output logic [LW-1:0]  max_q,
  output logic [47:0]    src_mac,
  output logic [LW-1:0]  out_len,
  output logic           rel_we,
  output logic           pkt_dec,
  output logic           done,
  output logic           busy
);
  rdq_state_e    state;
  logic [3:0]    idx;
  logic [7:0]    nxt_lo;
  logic [7:0]    type_hi;
  logic [LW-1:0] remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      cur_addr  <= AW'(RING_START);
      nxt_frame <= AW'(RING_START);
      nxt_lo    <= '0;
      byte_cnt  <= '0;
      type_hi   <= '0;
      type_lo   <= '0;
      max_q     <= '0;
      src_mac   <= '0;
      out_len   <= '0;
      out_data  <= '0;
      remaining <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          out_len <= '0;
          if (pkt_count == '0) begin
            state <= S_EMPTY;
          end else begin
            cur_addr <= nxt_frame;
            idx      <= '0;
            max_q    <= max_len;
            state    <= S_REQ;
          end
        end
        S_EMPTY: state <= S_IDLE;
        S_REQ:   if (mem_req_ready) state <= S_WAIT;
        S_WAIT:  if (mem_rsp_valid) begin
          state    <= S_REQ;
          cur_addr <= step_addr;
          if (idx != IDX_PAYLOAD) idx <= idx + 4'd1;
          case (idx)
            4'd0: nxt_lo <= mem_rdata;
            4'd1: nxt_frame <= {mem_rdata[AW-9:0], nxt_lo};
            4'd2: byte_cnt[7:0] <= mem_rdata;
            4'd3: begin
              byte_cnt[15:8] <= mem_rdata;
              cur_addr       <= skip_addr;
            end
            IDX_TYPE_HI: type_hi <= mem_rdata;
            IDX_TYPE_LO: begin
              type_lo <= mem_rdata;
              state   <= S_CALC;
            end
            IDX_PAYLOAD: begin
              out_data <= mem_rdata;
              state    <= S_OUT;
            end
            default: src_mac <= {src_mac[39:0], mem_rdata};
          endcase
        end
        S_CALC: begin
          out_len   <= deliver_len;
          remaining <= deliver_len;
          state     <= (deliver_len == '0) ? S_REL : S_REQ;
        end
        S_OUT: if (out_ready) begin
          remaining <= remaining - 1'b1;
          state     <= (remaining == LW'(1)) ? S_REL : S_REQ;
        end
        S_REL:   state <= S_DEC;
        S_DEC:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == S_REQ);
  assign out_valid     = (state == S_OUT);
  assign out_last      = (state == S_OUT) && (remaining == LW'(1));
  assign type_hi_zero  = (type_hi == '0);
  assign rel_we        = (state == S_REL);
  assign pkt_dec       = (state == S_DEC);
  assign done          = (state == S_DEC) || (state == S_EMPTY);
  assign busy          = (state != S_IDLE);

endmodule

// File: rtl/rdq_dequeue.sv
module rdq_dequeue
  import rdq_pkg::*;
#(
  parameter int AW         = 13,
  parameter int LW         = 8,
  parameter int PCW        = 8,
  parameter int RING_START = 0,
  parameter int RING_END   = 13'h19FD
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [PCW-1:0] pkt_count,
  input  logic [LW-1:0]  max_len,
  output logic           busy,
  output logic           done,
  output logic [LW-1:0]  out_len,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_rsp_valid,
  input  logic [7:0]     mem_rdata,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [7:0]     out_data,
  output logic           out_last,
  output logic [47:0]    src_mac,
  output logic           rel_we,
  output logic [AW-1:0]  rel_ptr,
  output logic           pkt_dec
);
  localparam int CW = 16;

  logic [AW-1:0] step_addr, skip_addr, nxt_frame;
  logic [CW-1:0] byte_cnt;
  logic          type_hi_zero;
  logic [LW-1:0] type_lo, max_q, deliver_len;

  rdq_seq #(
    .AW(AW), .LW(LW), .CW(CW), .PCW(PCW), .RING_START(RING_START)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pkt_count(pkt_count),
    .max_len(max_len), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .cur_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .step_addr(step_addr), .skip_addr(skip_addr),
    .deliver_len(deliver_len), .nxt_frame(nxt_frame), .byte_cnt(byte_cnt),
    .type_hi_zero(type_hi_zero), .type_lo(type_lo), .max_q(max_q),
    .src_mac(src_mac), .out_len(out_len), .rel_we(rel_we),
    .pkt_dec(pkt_dec), .done(done), .busy(busy)
  );

  rdq_ring_math #(
    .AW(AW), .RING_START(RING_START), .RING_END(RING_END), .SKIP(SKIP_TO_MAC)
  ) u_math (
    .cur_addr(mem_addr), .nxt_frame(nxt_frame), .step_addr(step_addr),
    .skip_addr(skip_addr), .rel_addr(rel_ptr)
  );

  rdq_len_calc #(
    .LW(LW), .CW(CW), .OVERHEAD(FRAME_OVERHEAD)
  ) u_len (
    .byte_cnt(byte_cnt), .max_len(max_q), .type_hi_zero(type_hi_zero),
    .type_lo(type_lo), .deliver_len(deliver_len)
  );

endmodule

// File: rtl/rdq_dequeue_chk.sv
module rdq_dequeue_chk #(
  parameter int AW         = 13,
  parameter int LW         = 8,
  parameter int PCW        = 8,
  parameter int RING_END   = 13'h19FD
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [PCW-1:0] pkt_count,
  input logic           busy,
  input logic           done,
  input logic           mem_req_valid,
  input logic           mem_req_ready,
  input logic [AW-1:0]  mem_addr,
  input logic           out_valid,
  input logic           out_ready,
  input logic [7:0]     out_data,
  input logic           out_last,
  input logic           rel_we,
  input logic [AW-1:0]  rel_ptr,
  input logic           pkt_dec
);
  localparam logic [AW-1:0] END_A = AW'(RING_END);

  // R13: request held until accepted
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));

  // R8: reads stay inside the ring
  a_r8_addr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_addr <= END_A);

  // R11: payload byte held under back-pressure
  a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R9: release pointer inside the ring
  a_r9_rel_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    rel_we |-> rel_ptr <= END_A);

  // R10: decrement follows the release write, once
  a_r10_dec_after_rel: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_dec |-> $past(rel_we) && done);
  a_r10_dec_single: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_dec |=> !pkt_dec);

  // R2: empty count ends at once, without a read
  a_r2_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) && !$past(busy) && ($past(pkt_count) == '0) |->
      done && !pkt_dec && !mem_req_valid);

  // R7: no payload while idle
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid && !rel_we);

endmodule

bind rdq_dequeue rdq_dequeue_chk #(
  .AW(AW), .LW(LW), .PCW(PCW), .RING_END(RING_END)
) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pkt_count(pkt_count),
  .busy(busy), .done(done), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .rel_we(rel_we), .rel_ptr(rel_ptr), .pkt_dec(pkt_dec)
);

// File: tb/test_rdq_dequeue.sv
module test_rdq_dequeue;
  localparam int CLK_PERIOD = 10;
  localparam int RING_END   = 'h19FD;
  localparam int RING_SIZE  = RING_END + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  pkt_count = '0;
  logic [7:0]  max_len = '0;
  logic        busy, done;
  logic [7:0]  out_len;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [12:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_last;
  logic [47:0] src_mac;
  logic        rel_we;
  logic [12:0] rel_ptr;
  logic        pkt_dec;

  rdq_dequeue i_rdq_dequeue (
    .clk(clk), .rst_n(rst_n), .start(start), .pkt_count(pkt_count),
    .max_len(max_len), .busy(busy), .done(done), .out_len(out_len),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .src_mac(src_mac),
    .rel_we(rel_we), .rel_ptr(rel_ptr), .pkt_dec(pkt_dec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int rmode = 0;
  int req_cnt = 0;
  int rel_cnt = 0;
  int dec_cnt = 0;
  int beat_cnt = 0;
  bit first_pending = 1'b0;
  logic [12:0] first_addr = '0;
  logic [12:0] got_rel = '0;
  bit prev_rel = 1'b0;
  bit hold_prev = 1'b0;
  logic [7:0] hold_data = '0;
  logic       hold_last = 1'b0;
  logic [7:0] mem [0:8191];
  logic [7:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  function automatic int phys(input int a);
    int r = a;
    while (r > RING_END) r -= RING_SIZE;
    return r;
  endfunction

  // memory model, handshake patterns and watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    out_ready     <= (rmode == 0) || (cyc % 3 != 0);
    mem_req_ready <= (rmode == 0) || (cyc % 4 != 1);
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    if (mem_req_valid && mem_req_ready) begin
      mem_rdata <= mem[mem_addr];
      req_cnt   <= req_cnt + 1;
      if (first_pending) begin
        first_addr    <= mem_addr;
        first_pending <= 1'b0;
      end
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      report();
      $finish;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev) begin
        chk(out_valid && out_data == hold_data && out_last == hold_last,
            "R11 hold", {out_valid, out_data}, {1'b1, hold_data});
      end
      hold_prev = out_valid && !out_ready;
      hold_data = out_data;
      hold_last = out_last;
      if (out_valid && out_ready) begin
        beat_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 extra beat", out_data, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R7 data", out_data, e);
          chk(out_last == (exp_q.size() == 0), "R7 last", out_last, exp_q.size() == 0);
        end
      end
      if (rel_we) begin
        got_rel = rel_ptr;
        rel_cnt++;
      end
      if (pkt_dec) begin
        dec_cnt++;
        chk(prev_rel, "R10 dec after rel", prev_rel, 1);
      end
      prev_rel = rel_we;
    end
  end

  task automatic run_frame(input int fs, input int np, input int cnt, input int hi,
                           input int lo, input int maxl, input logic [47:0] macv,
                           input int mode);
    int room, lim, elen, erel, dec0, rel0, wait_n;
    room = (cnt > 14) ? cnt - 14 : 0;
    lim  = (maxl < room) ? maxl : room;
    elen = (hi != 0) ? 0 : ((lo < lim) ? lo : lim);
    erel = (np == 0 || np - 1 > RING_END) ? RING_END : np - 1;
    mem[phys(fs)]     = 8'(np);
    mem[phys(fs + 1)] = 8'(np >> 8);
    mem[phys(fs + 2)] = 8'(cnt);
    mem[phys(fs + 3)] = 8'(cnt >> 8);
    mem[phys(fs + 4)] = 8'hA5;
    mem[phys(fs + 5)] = 8'h5A;
    for (int k = 0; k < 6; k++) mem[phys(fs + 12 + k)] = macv[47 - 8*k -: 8];
    mem[phys(fs + 18)] = 8'(hi);
    mem[phys(fs + 19)] = 8'(lo);
    for (int i = 0; i < lo; i++) begin
      mem[phys(fs + 20 + i)] = 8'(fs + i * 7 + 3);
      if (i < elen) exp_q.push_back(8'(fs + i * 7 + 3));
    end
    rmode = mode;
    dec0 = dec_cnt;
    rel0 = rel_cnt;
    pkt_count = 8'd1;
    max_len = 8'(maxl);
    first_pending = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    @(negedge clk);
    chk(wait_n < 5000, "R10 done seen", wait_n, 0);
    chk(first_addr == 13'(fs), "R12 first read address", first_addr, fs);
    chk(out_len == 8'(elen), "R4/R6/R7 out_len", out_len, elen);
    chk(src_mac == macv, "R5 src_mac", src_mac, macv);
    chk(exp_q.size() == 0, "R7 beats missing", exp_q.size(), 0);
    chk(got_rel == 13'(erel), "R9 rel_ptr", got_rel, erel);
    chk(rel_cnt == rel0 + 1, "R9 rel_we count", rel_cnt - rel0, 1);
    chk(dec_cnt == dec0 + 1, "R10 dec count", dec_cnt - dec0, 1);
    exp_q.delete();
  endtask

  task automatic run_empty();
    int r0, d0, b0;
    r0 = req_cnt; d0 = dec_cnt; b0 = beat_cnt;
    pkt_count = 8'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R2 done next cycle", done, 1);
    chk(out_len == 8'd0, "R2 out_len", out_len, 0);
    @(negedge clk);
    @(negedge clk);
    chk(req_cnt == r0, "R2 no memory read", req_cnt - r0, 0);
    chk(dec_cnt == d0 && beat_cnt == b0, "R2 no dec or payload", dec_cnt - d0, 0);
  endtask

  initial begin
    for (int a = 0; a < 8192; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !out_valid, "R1 idle outputs", {busy, done, out_valid}, 0);
    chk(!mem_req_valid && !rel_we && !pkt_dec, "R1 no requests",
        {mem_req_valid, rel_we, pkt_dec}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R3 R5 R7: first frame at ring start, full readiness
    run_frame('h0000, 'h0040, 44, 0, 16, 100, 48'h0211_2233_4455, 0);
    // R4: byte-count limit, back-pressure on both channels (R11 R13)
    run_frame('h0040, 'h0080, 19, 0, 20, 100, 48'h0A0B_0C0D_0E0F, 1);
    // R2 and R12: empty request keeps the next-frame address
    run_empty();
    // R4: max_len limit
    run_frame('h0080, 'h0100, 300, 0, 10, 3, 48'h1122_3344_5566, 1);
    // R6: high type byte set
    run_frame('h0100, 'h19E0, 100, 8, 4, 50, 48'hCAFE_0000_BEEF, 0);
    // R8: payload wraps over the ring end
    run_frame('h19E0, 'h19F0, 200, 0, 20, 255, 48'h7766_5544_3322, 1);
    // R8 R9: MAC wraps, next frame 0 clamps release to the end
    run_frame('h19F0, 'h0000, 60, 0, 8, 255, 48'hF0E1_D2C3_B4A5, 1);
    // R4 R9: short frame gives nothing, release above ring clamps
    run_frame('h0000, 'h1A00, 10, 0, 5, 255, 48'h0102_0304_0506, 0);
    report();
    $finish;
  end

endmodule